// File: doc/BRIEF.md
# I2C Transmit-Only Bus Master

This block is a single-master I2C transmitter. Software controls it through two byte-wide registers: a control register and a data register that also returns a status byte on read. Software loads the first address byte and then sets the start request. The controller then drives a START condition and shifts the byte out MSB first on SDA, with SCL generated from a programmable divider. It samples the acknowledge slot and carries on with later bytes while software keeps the data register fed. A transfer ends when software requests a STOP or a repeated START. Both bus lines are open-drain: the block only drives them low and reads SDA back.

The data register's empty flag sets as soon as the first bit of a byte has been clocked. Software can therefore preload the next byte, or post the end-of-transfer request, while the current byte is still on the bus. A request that is already pending when the acknowledge slot is sampled suppresses the not-acknowledge interrupt. The controller clears each request by itself once the matching bus condition has been produced. A 10-bit address probe, where only the address bytes are sent, is a two-byte transfer closed with STOP.

The state machine has seven states. IDLE has both lines released and goes to START when the start request is set and a byte is loaded. START drives SDA low with SCL high and then enters BIT. BIT shifts eight bits and then enters ACK. ACK samples the slave and then goes to STOP (stop requested), to RSTART (start requested and byte loaded), to BIT (acknowledged and next byte loaded) or to HOLD (any other case). HOLD keeps SCL low and leaves to STOP, RSTART or BIT when a request or a byte arrives. RSTART releases SDA, raises SCL, pulls SDA low and then enters BIT. STOP raises SDA while SCL is high and returns to IDLE. When the enable bit is cleared, the machine returns to IDLE from any state.

Top module: `i2c_txm`

## Requirements
- R1: After reset the control read is 0x00, the status read is 0x80, `irq` is 0 and neither bus line is driven low.
- R2: `irq` is high exactly when the enable bit is set and either (transmit-interrupt enable and data empty) or the not-acknowledge flag is set.
- R3: While SCL is high, SDA changes only to form START or repeated START (falling) and STOP (rising). Each transfer produces exactly one START and one STOP as seen on the lines.
- R4: With a byte loaded and the start request set, the controller issues START and shifts the byte MSB first: eight SCL pulses followed by one acknowledge pulse with SDA released.
- R5: The empty flag (and so the transmit interrupt) asserts after the first bit of a byte has been clocked, while the slave has seen exactly one bit of that byte.
- R6: A STOP or START request posted while a byte is shifting takes effect only after that byte and its acknowledge slot. A NACK sampled while a request is pending does not set the not-acknowledge flag. Clearing transmit-interrupt enable together with STOP leaves `irq` low.
- R7: The start-request bit clears by itself after START or repeated START has been driven, and the stop-request bit clears after STOP.
- R8: A NACK with no request pending sets the not-acknowledge flag and parks the bus with SCL low. Writing the control register with the start bit set clears the flag, and once a byte is loaded the controller issues a repeated START and resends.
- R9: A 10-bit address-only probe (first byte 11110xx0, then the second address byte, then STOP) puts exactly those two bytes on the bus between one START and one STOP.
- R10: The last-acknowledge status bit holds the value sampled in the most recent acknowledge slot (0 = ACK, 1 = NACK).
- R11: Register encodings. Write address 0 (control): bit 7 enable, bit 6 transmit-interrupt enable, bit 5 start request, bit 4 stop request. Write address 1 loads the transmit byte and clears empty. Read address 0 returns the control bits in the same positions. Read address 1 returns bit 7 empty, bit 6 not-acknowledge flag, bit 5 last acknowledge, bit 4 busy. Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_div | input | DIV_W | Quarter SCL period, in system clocks minus one |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 control, 1 transmit byte |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read select: 0 control, 1 status |
| rd_data | output | 8 | Read data (combinational) |
| irq | output | 1 | Interrupt request to software |
| scl_low | output | 1 | Pull SCL low when 1 |
| sda_low | output | 1 | Pull SDA low when 1 |
| sda_i | input | 1 | Sampled level of the SDA line |

## Verification
The hardest situation to reach from the ports is a slave NACK on the final byte while a STOP or repeated START request is already posted. The request has to land after the byte has started but before its acknowledge slot. The bench reaches it by reacting to the transmit interrupt, which rises one bit into the byte. It writes the request in the next few cycles, while the behavioral slave is set to NACK that byte index, and then checks that the not-acknowledge flag stays clear. The NACK-then-retry path is reached in the same way with no request posted, and the bench checks that SCL stays parked low until the retry write.

// File: rtl/i2c_txm_pkg.sv
package i2c_txm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_RSTART = 3'd2,
        ST_BIT    = 3'd3,
        ST_ACK    = 3'd4,
        ST_HOLD   = 3'd5,
        ST_STOP   = 3'd6
    } txm_state_t;

    localparam int CTL_EN    = 7;
    localparam int CTL_TXIE  = 6;
    localparam int CTL_START = 5;
    localparam int CTL_STOP  = 4;

    localparam int STS_EMPTY   = 7;
    localparam int STS_NACK    = 6;
    localparam int STS_LASTACK = 5;
    localparam int STS_BUSY    = 4;

endpackage

// File: rtl/i2c_txm_tick.sv
module i2c_txm_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic [1:0]       phase,
    output logic             slot_end
);
    logic [DIV_W-1:0] cnt_q;
    logic             tick;

    assign tick     = run && (cnt_q == div);
    assign slot_end = tick && (phase == 2'd3);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            phase <= 2'd0;
        end else if (tick) begin
            cnt_q <= '0;
            phase <= phase + 2'd1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3: the bit timing advances only on a divider tick
    a_r3_phase_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && (phase != $past(phase))) |-> $past(tick));

endmodule

// File: rtl/i2c_txm_regs.sv
module i2c_txm_regs
    import i2c_txm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    input  logic       rd_addr,
    input  logic       consume,
    input  logic       clr_start,
    input  logic       clr_stop,
    input  logic       ack_valid,
    input  logic       ack_val,
    input  logic       nack_evt,
    input  logic       busy,
    output logic       en,
    output logic       start_req,
    output logic       stop_req,
    output logic       data_full,
    output logic       nack_pend,
    output logic [7:0] tx_byte,
    output logic [7:0] rd_data,
    output logic       irq
);
    logic txie, empty_q, last_ack_q;
    logic ctl_wr, dat_wr;

    assign ctl_wr    = wr_en && (wr_addr == 1'b0);
    assign dat_wr    = wr_en && (wr_addr == 1'b1);
    assign data_full = !empty_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en        <= 1'b0;
            txie      <= 1'b0;
            start_req <= 1'b0;
            stop_req  <= 1'b0;
        end else if (ctl_wr) begin
            en        <= wr_data[CTL_EN];
            txie      <= wr_data[CTL_TXIE];
            start_req <= wr_data[CTL_START];
            stop_req  <= wr_data[CTL_STOP];
        end else begin
            if (clr_start) start_req <= 1'b0;
            if (clr_stop)  stop_req  <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_byte <= '0;
            empty_q <= 1'b1;
        end else if (dat_wr) begin
            tx_byte <= wr_data;
            empty_q <= 1'b0;
        end else if (consume) begin
            empty_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nack_pend  <= 1'b0;
            last_ack_q <= 1'b0;
        end else begin
            if (ack_valid) last_ack_q <= ack_val;
            if (nack_evt)  nack_pend  <= 1'b1;
            if (ctl_wr && (wr_data[CTL_START] || wr_data[CTL_STOP] || !wr_data[CTL_EN]))
                nack_pend <= 1'b0;
        end
    end

    assign irq = en && ((txie && empty_q) || nack_pend);

    always_comb begin
        rd_data = '0;
        if (rd_addr == 1'b0) begin
            rd_data[CTL_EN]    = en;
            rd_data[CTL_TXIE]  = txie;
            rd_data[CTL_START] = start_req;
            rd_data[CTL_STOP]  = stop_req;
        end else begin
            rd_data[STS_EMPTY]   = empty_q;
            rd_data[STS_NACK]    = nack_pend;
            rd_data[STS_LASTACK] = last_ack_q;
            rd_data[STS_BUSY]    = busy;
        end
    end

    // R8: the flag only rises after an acknowledge slot that saw a NACK
    a_r8_nack_from_slot: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nack_pend) |-> ($past(ack_valid) && $past(ack_val)));

endmodule

// File: rtl/i2c_txm_fsm.sv
module i2c_txm_fsm
    import i2c_txm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] phase,
    input  logic       slot_end,
    input  logic       sda_i,
    input  logic       start_req,
    input  logic       stop_req,
    input  logic       data_full,
    input  logic       nack_pend,
    input  logic [7:0] tx_byte,
    output txm_state_t state,
    output logic       busy,
    output logic       consume,
    output logic       clr_start,
    output logic       clr_stop,
    output logic       ack_valid,
    output logic       ack_val,
    output logic       nack_evt,
    output logic       scl_low,
    output logic       sda_low
);
    txm_state_t next;
    logic [7:0] shreg;
    logic [2:0] bit_cnt;
    logic       scl_q, sda_q, scl_d, sda_d, scl_hi_ph;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next;
    end

    always_comb begin
        next = state;
        unique case (state)
            ST_IDLE:   if (slot_end && start_req && data_full) next = ST_START;
            ST_START:  if (slot_end) next = ST_BIT;
            ST_RSTART: if (slot_end) next = ST_BIT;
            ST_BIT:    if (slot_end && bit_cnt == 3'd0) next = ST_ACK;
            ST_ACK: if (slot_end) begin
                if (stop_req)                    next = ST_STOP;
                else if (start_req)              next = data_full ? ST_RSTART : ST_HOLD;
                else if (!sda_i && data_full)    next = ST_BIT;
                else                             next = ST_HOLD;
            end
            ST_HOLD: if (slot_end) begin
                if (stop_req)                            next = ST_STOP;
                else if (start_req && data_full)         next = ST_RSTART;
                else if (!start_req && !nack_pend && data_full) next = ST_BIT;
            end
            ST_STOP:   if (slot_end) next = ST_IDLE;
            default:   next = ST_IDLE;
        endcase
        if (!en) next = ST_IDLE;
    end

    // shift register and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (slot_end && next == ST_BIT && state != ST_BIT) begin
            shreg   <= tx_byte;
            bit_cnt <= 3'd7;
        end else if (slot_end && state == ST_BIT) begin
            shreg   <= {shreg[6:0], 1'b0};
            bit_cnt <= bit_cnt - 3'd1;
        end
    end

    assign busy      = (state != ST_IDLE);
    assign consume   = slot_end && (state == ST_BIT) && (bit_cnt == 3'd7);
    assign clr_start = slot_end && (state == ST_START || state == ST_RSTART);
    assign clr_stop  = slot_end && (state == ST_STOP);
    assign ack_valid = slot_end && (state == ST_ACK);
    assign ack_val   = sda_i;
    assign nack_evt  = ack_valid && sda_i && !start_req && !stop_req;

    // output decode: line levels, 1 = released
    assign scl_hi_ph = (phase >= 2'd2);
    always_comb begin
        scl_d = 1'b1;
        sda_d = sda_q;
        unique case (state)
            ST_IDLE:   begin scl_d = 1'b1;      sda_d = 1'b1; end
            ST_START:  begin scl_d = 1'b1;      sda_d = (phase != 2'd3); end
            ST_RSTART: begin scl_d = scl_hi_ph; if (phase != 2'd0) sda_d = (phase != 2'd3); end
            ST_BIT:    begin scl_d = scl_hi_ph; if (phase != 2'd0) sda_d = shreg[7]; end
            ST_ACK:    begin scl_d = scl_hi_ph; if (phase != 2'd0) sda_d = 1'b1; end
            ST_HOLD:   begin scl_d = 1'b0; end
            ST_STOP:   begin scl_d = scl_hi_ph; if (phase != 2'd0) sda_d = (phase == 2'd3); end
            default:   begin scl_d = 1'b1;      sda_d = 1'b1; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    assign scl_low = !scl_q;
    assign sda_low = !sda_q;

    // R3: SDA moves under a high SCL only while forming START/RSTART/STOP
    a_r3_sda_stable_while_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && scl_q && $past(scl_q) && (sda_q != $past(sda_q)))
        |-> ($past(state) == ST_START || $past(state) == ST_RSTART || $past(state) == ST_STOP));

    // R8: a parked bus keeps SCL low
    a_r8_hold_keeps_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && $past(state) == ST_HOLD) |-> scl_low);

endmodule

// File: rtl/i2c_txm.sv
module i2c_txm
    import i2c_txm_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             rd_addr,
    output logic [7:0]       rd_data,
    output logic             irq,
    output logic             scl_low,
    output logic             sda_low,
    input  logic             sda_i
);
    logic [1:0] phase;
    logic       slot_end, en, start_req, stop_req, data_full, nack_pend;
    logic       busy, consume, clr_start, clr_stop, ack_valid, ack_val, nack_evt;
    logic [7:0] tx_byte;
    txm_state_t state;

    i2c_txm_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(en), .div(clk_div),
        .phase(phase), .slot_end(slot_end)
    );

    i2c_txm_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .consume(consume),
        .clr_start(clr_start), .clr_stop(clr_stop), .ack_valid(ack_valid),
        .ack_val(ack_val), .nack_evt(nack_evt), .busy(busy), .en(en),
        .start_req(start_req), .stop_req(stop_req), .data_full(data_full),
        .nack_pend(nack_pend), .tx_byte(tx_byte), .rd_data(rd_data), .irq(irq)
    );

    i2c_txm_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en), .phase(phase), .slot_end(slot_end),
        .sda_i(sda_i), .start_req(start_req), .stop_req(stop_req),
        .data_full(data_full), .nack_pend(nack_pend), .tx_byte(tx_byte),
        .state(state), .busy(busy), .consume(consume), .clr_start(clr_start),
        .clr_stop(clr_stop), .ack_valid(ack_valid), .ack_val(ack_val),
        .nack_evt(nack_evt), .scl_low(scl_low), .sda_low(sda_low)
    );

    // R5: the data register empties only at the end of a bit slot
    a_r5_empty_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_full) |-> ($past(state) == ST_BIT));

    // R7: a stop request disappears without a write only as STOP completes
    a_r7_stop_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(stop_req) && !$past(wr_en && !wr_addr)) |-> ($past(state) == ST_STOP));

    // R6: a pending request masks the not-acknowledge flag
    a_r6_nack_masked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nack_pend) |-> (!$past(start_req) && !$past(stop_req)));

endmodule

// File: tb/i2c_txm_tb.sv
`timescale 1ns/1ps
module i2c_txm_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] clk_div = 8'd1;
    logic       wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq, scl_low, sda_low, sda_line, scl_line;
    logic       slave_low = 1'b0;

    always #4 clk = ~clk;

    assign scl_line = ~scl_low;
    assign sda_line = ~(sda_low | slave_low);

    i2c_txm u_dut (
        .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq), .scl_low(scl_low), .sda_low(sda_low),
        .sda_i(sda_line)
    );

    localparam logic [7:0] EN = 8'h80, TXIE = 8'h40, STA = 8'h20, STO = 8'h10;

    // behavioral slave
    int         bit_n = 0, byte_in_txn = 0, ncap = 0, starts = 0, stops = 0;
    int         nack_idx = -1;
    logic [7:0] sh = '0;
    logic [7:0] cap [0:63];

    always @(negedge sda_line) if (scl_line) begin
        starts++; bit_n = 0; byte_in_txn = 0;
    end
    always @(posedge sda_line) if (scl_line) stops++;
    always @(posedge scl_line) begin
        if (bit_n < 8) begin
            sh = {sh[6:0], sda_line};
            bit_n++;
            if (bit_n == 8) begin cap[ncap] = sh; ncap++; end
        end else begin
            bit_n = 9;
        end
    end
    always @(negedge scl_line) begin
        if (bit_n == 8) begin
            slave_low = (byte_in_txn != nack_idx);
            byte_in_txn++;
        end else if (bit_n == 9) begin
            slave_low = 1'b0;
            bit_n = 0;
        end
    end

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk); rd_addr = a; #1 d = rd_data;
    endtask

    task automatic wait_irq(input string req);
        int t = 0;
        while (irq !== 1'b1 && t < 2000) begin @(negedge clk); t++; end
        if (t >= 2000) chk({req, " irq timeout"}, 0, 1);
    endtask

    task automatic wait_sts(input int b, input logic v, input string req);
        logic [7:0] s;
        int t = 0;
        rd(1'b1, s);
        while (s[b] !== v && t < 2000) begin rd(1'b1, s); t++; end
        if (t >= 2000) chk({req, " status timeout"}, 0, 1);
    endtask

    // vector table: {first byte, second byte, slave NACKs second byte}
    localparam logic [16:0] VEC [4] = '{
        {8'hF0, 8'h5A, 1'b0},
        {8'hF6, 8'hC3, 1'b1},
        {8'hA4, 8'h81, 1'b0},
        {8'hF2, 8'h3C, 1'b1}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk("watchdog", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        int s0, p0, c0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R11 reset state
        rd(1'b0, r); chk("R1 ctrl", r, 8'h00);
        rd(1'b1, r); chk("R1 R11 status", r, 8'h80);
        chk("R1 irq", irq, 0);
        chk("R1 lines", {scl_low, sda_low}, 2'b00);
        // R2: enabled without transmit-interrupt enable
        wr(1'b0, EN); chk("R2 irq no txie", irq, 0);

        // table walk
        for (int i = 0; i < 4; i++) begin
            logic [7:0] b0, b1;
            logic       nk;
            {b0, b1, nk} = VEC[i];
            nack_idx = nk ? 1 : -1;
            s0 = starts; p0 = stops; c0 = ncap;
            wr(1'b0, EN | TXIE); chk("R2 irq empty", irq, 1);
            wr(1'b1, b0);        chk("R2 irq loaded", irq, 0);
            wr(1'b0, EN | TXIE | STA);
            wait_irq("R5");      chk("R5 first byte bits", bit_n, 1);
            wr(1'b1, b1);
            wait_irq("R5");      chk("R5 second byte bits", bit_n, 1);
            wr(1'b0, EN | STO);  chk("R6 irq after stop", irq, 0);
            wait_sts(4, 1'b0, "R7");
            repeat (4) @(negedge clk);
            chk("R4 byte0 msb first", cap[c0], b0);
            chk("R9 byte1", cap[c0+1], b1);
            chk("R3 starts", starts - s0, 1);
            chk("R3 stops", stops - p0, 1);
            rd(1'b0, r); chk("R7 ctrl cleared", r, EN);
            rd(1'b1, r); chk("R6 R10 status", r, {1'b1, 1'b0, nk, 5'b0});
            chk("R6 irq idle", irq, 0);
        end

        // R8: NACK of the first byte with nothing pending, then retry
        nack_idx = 0; s0 = starts; c0 = ncap;
        wr(1'b1, 8'hF4);
        wr(1'b0, EN | TXIE | STA);
        wait_irq("R8");
        wr(1'b0, EN);
        chk("R2 irq txie off", irq, 0);
        wait_sts(6, 1'b1, "R8");
        chk("R8 irq on nack", irq, 1);
        rd(1'b1, r); chk("R8 R10 status", r, 8'hF0);
        repeat (40) @(negedge clk);
        chk("R8 scl parked", scl_low, 1);
        chk("R8 no new start", starts - s0, 1);
        nack_idx = -1;
        wr(1'b1, 8'hF4);
        wr(1'b0, EN | TXIE | STA);
        chk("R8 flag cleared", irq, 0);
        wait_irq("R8");
        chk("R8 repeated start", starts - s0, 2);
        rd(1'b0, r); chk("R7 start cleared", r, EN | TXIE);
        wr(1'b1, 8'h11);
        wait_irq("R8");
        wr(1'b0, EN | STO);
        wait_sts(4, 1'b0, "R8");
        repeat (4) @(negedge clk);
        chk("R8 resent byte", cap[c0+1], 8'hF4);
        chk("R8 data byte", cap[c0+2], 8'h11);

        // R6: repeated START posted during a byte the slave NACKs
        nack_idx = 1; s0 = starts; p0 = stops; c0 = ncap;
        wr(1'b1, 8'hA0);
        wr(1'b0, EN | TXIE | STA);
        wait_irq("R6");
        wr(1'b1, 8'h42);
        wait_irq("R6");
        wr(1'b1, 8'hA2);
        wr(1'b0, EN | TXIE | STA);
        rd(1'b0, r); chk("R6 start still pending", r, EN | TXIE | STA);
        chk("R6 byte not cut", bit_n >= 1 && bit_n <= 8, 1);
        wait_irq("R6");
        chk("R6 restart after ack", starts - s0, 2);
        rd(1'b0, r); chk("R7 restart cleared", r, EN | TXIE);
        rd(1'b1, r); chk("R6 nack masked", r[6], 0);
        chk("R10 last ack nack", r[5], 1);
        wr(1'b0, EN | STO);
        wait_sts(4, 1'b0, "R6");
        repeat (4) @(negedge clk);
        chk("R6 bytes", {cap[c0], cap[c0+1], cap[c0+2]}, {8'hA0, 8'h42, 8'hA2});
        chk("R3 one stop", stops - p0, 1);
        rd(1'b1, r); chk("R10 last ack ok", r, 8'h80);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule